// File: doc/BRIEF.md
# Ethernet Event Status and Interrupt Register Unit

This block is the byte-wide host register file that sits beside the transmit and receive engines of a simple Ethernet controller. The engines report events (frame sent, collision, CRC error, overrun and so on) as single-cycle pulses. The unit latches each pulse into a sticky status bit. The host clears a status bit by writing 1 to its position at the status address. A per-bit enable mask selects which pending bits raise an interrupt. The two resulting interrupt lines are active low and are also visible in a read-only summary register.

The unit also holds three other registers. The transmit mode register has four writable control bits under a read-only collision counter. The receive mode register carries the accept policy. The hold register keeps both engines in reset while its top bit is 1. Host reads are registered: the data returned is the register contents as they stood before the clock edge that samples the address.

Top module: `eirq_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, the summary register (address 7) reads 0x03, both interrupt pins are 1, and the engine hold and policy outputs are 0.
- R2: An event pulse sets its status bit on the clock edge where it is present. The transmit status (address 0) uses all eight bits, with bit7 send OK and bit2 collision. The receive status (address 2) uses bits 7 and 4..0. Receive bits 6 and 5 always read 0.
- R3: A write to a status address clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The transmit mask (address 1, 8 bits) and the receive mask (address 3, bits 7 and 4..0) read back the value written. A mask bit of 1 enables its event as an interrupt source.
- R6: The summary register (address 7) has bit0 = 0 exactly when a transmit status bit and its mask bit are both 1, and bit1 = 0 exactly when the same holds on the receive side. Bits 7..2 read 0. The pins `tx_irq_n` and `rx_irq_n` carry the same values.
- R7: In the transmit mode register (address 4), bits 3..0 are read/write and writes to bits 7..4 are ignored. The receive mode register (address 5) is read/write, and its bits 1..0 drive `rx_policy` (0 none, 1 broadcast plus own, 2 plus multicast, 3 all).
- R8: Bits 7..4 of address 4 count collision pulses and saturate at 15. A send-OK pulse clears the count, and it wins over a collision pulse in the same cycle.
- R9: While bit7 of the hold register (address 6) is 1, `engine_hold` is 1, all status bits and the collision count are 0, and new event pulses are ignored. Writing 0 releases the hold.
- R10: Read data appears on `host_rdata` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| tx_evt | input | 8 | Transmit event pulses, one per status bit |
| rx_evt | input | 8 | Receive event pulses, bits 6 and 5 unused |
| tx_irq_n | output | 1 | Active-low transmit interrupt |
| rx_irq_n | output | 1 | Active-low receive interrupt |
| engine_hold | output | 1 | Holds the engines in reset |
| tx_ctl | output | 4 | Transmit mode control bits |
| rx_mode | output | 8 | Receive mode register |
| rx_policy | output | 2 | Receive accept policy |

## Verification
A pulse or host write takes effect in the status, mask and mode registers on the edge where it is present. The registered interrupt pins follow one edge later. A read returns the pre-edge contents one edge after its address is presented, so the summary register lags a status change by two edges. The bench drives one operation per cycle and samples 1 ns after each edge. It inserts an idle read wherever the summary or a hold effect is still in flight, and it checks pins only after that two-edge delay.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int DW       = 8;
  localparam int AW       = 3;
  localparam int CNT_W    = 4;
  localparam int CTL_W    = DW - CNT_W;
  localparam int HOLD_BIT = 7;
  localparam int TXB_OK   = 7;
  localparam int TXB_COLL = 2;

  localparam logic [DW-1:0] TX_VALID = 8'hFF;
  localparam logic [DW-1:0] RX_VALID = 8'h9F;

  typedef enum logic [AW-1:0] {
    A_TXST   = 3'd0,
    A_TXMSK  = 3'd1,
    A_RXST   = 3'd2,
    A_RXMSK  = 3'd3,
    A_TXMODE = 3'd4,
    A_RXMODE = 3'd5,
    A_HOLD   = 3'd6,
    A_SUMM   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/eirq_stat_bank.sv
module eirq_stat_bank #(
  parameter int          W     = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         irq_n
);
  logic [W-1:0] evt_v;
  logic [W-1:0] wd_v;
  logic [W-1:0] clr_v;

  assign evt_v = evt & VALID;
  assign wd_v  = wdata & VALID;
  assign clr_v = clr_we ? wd_v : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst || hold) stat[i] <= 1'b0;
        else if (evt_v[i]) stat[i] <= 1'b1;
        else if (clr_v[i]) stat[i] <= 1'b0;
      end
      always_ff @(posedge clk) begin
        if (rst) mask[i] <= 1'b0;
        else if (mask_we) mask[i] <= wd_v[i];
      end
    end else begin : g_tie
      assign stat[i] = 1'b0;
      assign mask[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else irq_n <= ~|(stat & mask);
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!hold && |(clr_v & ~evt_v)) |=> ((stat & $past(clr_v & ~evt_v)) == '0)); // R3
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !hold |=> ((stat & $past(stat & ~clr_v)) == $past(stat & ~clr_v))); // R3
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (!hold && |evt_v) |=> ((stat & $past(evt_v)) == $past(evt_v))); // R4
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold |=> (stat == '0)); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((stat | mask) & ~VALID) == '0); // R2
  AST_MASK_RB: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask == $past(wd_v))); // R5
endmodule

// File: rtl/eirq_coll_cnt.sv
module eirq_coll_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          coll,
  input  logic          ok,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || hold || ok) cnt <= '0;
    else if (coll && cnt != MAX) cnt <= cnt + 1'b1;
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAX && coll && !ok && !hold) |=> (cnt == MAX)); // R8
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (rst)
    (ok || hold) |=> (cnt == '0)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ok && !hold && !coll) |=> $stable(cnt)); // R8
endmodule

// File: rtl/eirq_mode_regs.sv
module eirq_mode_regs #(
  parameter int CTLW = 4,
  parameter int MW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_we,
  input  logic [CTLW-1:0] ctl_wd,
  input  logic            mode_we,
  input  logic [MW-1:0]   mode_wd,
  input  logic            hold_we,
  input  logic            hold_wd,
  output logic [CTLW-1:0] ctl,
  output logic [MW-1:0]   mode,
  output logic            hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      mode <= '0;
      hold <= 1'b0;
    end else begin
      if (ctl_we)  ctl  <= ctl_wd;
      if (mode_we) mode <= mode_wd;
      if (hold_we) hold <= hold_wd;
    end
  end

  AST_HOLD_TRACKS: assert property (@(posedge clk) disable iff (rst)
    hold_we |=> (hold == $past(hold_wd))); // R9
  AST_CTL_STABLE: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(ctl)); // R7
endmodule

// File: rtl/eirq_unit.sv
module eirq_unit
  import eirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] tx_evt,
  input  logic [DW-1:0] rx_evt,
  output logic          tx_irq_n,
  output logic          rx_irq_n,
  output logic          engine_hold,
  output logic [CTL_W-1:0] tx_ctl,
  output logic [DW-1:0] rx_mode,
  output logic [1:0]    rx_policy
);
  logic [DW-1:0]    tx_stat, tx_mask, rx_stat, rx_mask;
  logic [CNT_W-1:0] coll_cnt;
  logic [DW-1:0]    rd_next;
  logic [DW-1:0]    we;

  for (genvar a = 0; a < DW; a++) begin : g_dec
    assign we[a] = host_wr && (host_addr == a[AW-1:0]);
  end

  eirq_stat_bank #(.W(DW), .VALID(TX_VALID)) u_tx (
    .clk(clk), .rst(rst), .hold(engine_hold), .evt(tx_evt),
    .clr_we(we[A_TXST]), .mask_we(we[A_TXMSK]), .wdata(host_wdata),
    .stat(tx_stat), .mask(tx_mask), .irq_n(tx_irq_n));

  eirq_stat_bank #(.W(DW), .VALID(RX_VALID)) u_rx (
    .clk(clk), .rst(rst), .hold(engine_hold), .evt(rx_evt),
    .clr_we(we[A_RXST]), .mask_we(we[A_RXMSK]), .wdata(host_wdata),
    .stat(rx_stat), .mask(rx_mask), .irq_n(rx_irq_n));

  eirq_coll_cnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(engine_hold),
    .coll(tx_evt[TXB_COLL]), .ok(tx_evt[TXB_OK]), .cnt(coll_cnt));

  eirq_mode_regs #(.CTLW(CTL_W), .MW(DW)) u_mode (
    .clk(clk), .rst(rst),
    .ctl_we(we[A_TXMODE]), .ctl_wd(host_wdata[CTL_W-1:0]),
    .mode_we(we[A_RXMODE]), .mode_wd(host_wdata),
    .hold_we(we[A_HOLD]), .hold_wd(host_wdata[HOLD_BIT]),
    .ctl(tx_ctl), .mode(rx_mode), .hold(engine_hold));

  assign rx_policy = rx_mode[1:0];

  always_comb begin
    rd_next = '0;
    case (reg_addr_e'(host_addr))
      A_TXST:   rd_next = tx_stat;
      A_TXMSK:  rd_next = tx_mask;
      A_RXST:   rd_next = rx_stat;
      A_RXMSK:  rd_next = rx_mask;
      A_TXMODE: rd_next = {coll_cnt, tx_ctl};
      A_RXMODE: rd_next = rx_mode;
      A_HOLD:   rd_next[HOLD_BIT] = engine_hold;
      A_SUMM:   rd_next[1:0] = {rx_irq_n, tx_irq_n};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else host_rdata <= rd_next;
  end

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((tx_stat & tx_mask) == '0 && (rx_stat & rx_mask) == '0) |=> (tx_irq_n && rx_irq_n)); // R6
  AST_HOLD_NO_CNT: assert property (@(posedge clk) disable iff (rst)
    engine_hold |=> (coll_cnt == '0)); // R9
endmodule

// File: tb/tb_eirq_unit.sv
module tb_eirq_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] tx_evt = '0;
  logic [7:0] rx_evt = '0;
  logic       tx_irq_n, rx_irq_n, engine_hold;
  logic [3:0] tx_ctl;
  logic [7:0] rx_mode;
  logic [1:0] rx_policy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eirq_unit dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .tx_irq_n(tx_irq_n), .rx_irq_n(rx_irq_n),
    .engine_hold(engine_hold), .tx_ctl(tx_ctl), .rx_mode(rx_mode),
    .rx_policy(rx_policy));

  // op: 0 write, 1 read-check, 2 tx pulse, 3 rx pulse ; {op, addr, data, exp}
  localparam int NV = 28;
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 3'd0, 8'h00, 8'h00},  // R1
    {2'd1, 3'd7, 8'h00, 8'h03},  // R1
    {2'd2, 3'd0, 8'h84, 8'h00},
    {2'd1, 3'd0, 8'h00, 8'h84},  // R2
    {2'd0, 3'd0, 8'h80, 8'h00},
    {2'd1, 3'd0, 8'h00, 8'h04},  // R3
    {2'd3, 3'd0, 8'hFF, 8'h00},
    {2'd1, 3'd2, 8'h00, 8'h9F},  // R2
    {2'd0, 3'd2, 8'h0F, 8'h00},
    {2'd1, 3'd2, 8'h00, 8'h90},  // R3
    {2'd0, 3'd3, 8'hFF, 8'h00},
    {2'd1, 3'd3, 8'h00, 8'h9F},  // R5
    {2'd1, 3'd7, 8'h00, 8'h01},  // R6
    {2'd0, 3'd1, 8'h04, 8'h00},
    {2'd1, 3'd1, 8'h00, 8'h04},  // R5
    {2'd1, 3'd7, 8'h00, 8'h00},  // R6
    {2'd0, 3'd0, 8'hFF, 8'h00},
    {2'd0, 3'd2, 8'hFF, 8'h00},
    {2'd1, 3'd0, 8'h00, 8'h00},  // R3
    {2'd1, 3'd7, 8'h00, 8'h03},  // R6
    {2'd0, 3'd4, 8'hFF, 8'h00},
    {2'd1, 3'd4, 8'h00, 8'h0F},  // R7
    {2'd0, 3'd5, 8'h03, 8'h00},
    {2'd1, 3'd5, 8'h00, 8'h03},  // R7
    {2'd2, 3'd0, 8'h04, 8'h00},
    {2'd2, 3'd0, 8'h04, 8'h00},
    {2'd2, 3'd0, 8'h04, 8'h00},
    {2'd1, 3'd4, 8'h00, 8'h3F}   // R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    host_addr = a;
    tick();
    check(req, host_rdata, exp);
  endtask

  task automatic txp(input logic [7:0] d);
    tx_evt = d; tick(); tx_evt = '0;
  endtask

  task automatic rxp(input logic [7:0] d);
    rx_evt = d; tick(); rx_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][20:19])
        2'd0: wr(VEC[i][18:16], VEC[i][15:8]);
        2'd1: rd(VEC[i][18:16], VEC[i][7:0], $sformatf("table%0d R1-R8 R10", i));
        2'd2: txp(VEC[i][15:8]);
        default: rxp(VEC[i][15:8]);
      endcase
    end

    // R1: reset returns everything to idle
    rst = 1'b1; tick(); rst = 1'b0;
    for (int a = 0; a < 7; a++) rd(a[2:0], 8'h00, "R1 reg");
    rd(3'd7, 8'h03, "R1 summary");
    check("R1 pins", {4'h0, tx_irq_n, rx_irq_n, engine_hold, |rx_policy}, 8'h0C);

    // R4: event beats simultaneous clear
    tx_evt = 8'h02; host_addr = 3'd0; host_wdata = 8'h02; host_wr = 1'b1;
    tick();
    tx_evt = '0; host_wr = 1'b0;
    rd(3'd0, 8'h02, "R4 evt wins");

    // R9: hold clears and ignores
    wr(3'd6, 8'h80);
    check("R9 pin", {7'd0, engine_hold}, 8'h01);
    rd(3'd6, 8'h80, "R9 readback");
    rd(3'd0, 8'h00, "R9 cleared");
    rxp(8'h80);
    txp(8'h04); txp(8'h04);
    rd(3'd2, 8'h00, "R9 rx ignored");
    rd(3'd4, 8'h00, "R9 count held");
    wr(3'd6, 8'h00);
    rxp(8'h80);
    rd(3'd2, 8'h80, "R9 release");

    // R8: saturation and clear
    for (int k = 0; k < 17; k++) txp(8'h04);
    rd(3'd4, 8'hF0, "R8 saturate");
    txp(8'h84);
    rd(3'd4, 8'h00, "R8 ok wins");

    // R6: interrupt pin timing
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h80);
    txp(8'h80);
    tick();
    check("R6 tx pin low", {7'd0, tx_irq_n}, 8'h00);
    wr(3'd0, 8'h80);
    tick();
    check("R6 tx pin high", {7'd0, tx_irq_n}, 8'h01);

    // R7: policy pin and upper nibble ignored
    wr(3'd5, 8'h02);
    check("R7 policy", {6'd0, rx_policy}, 8'h02);
    wr(3'd4, 8'hA5);
    rd(3'd4, 8'h05, "R7 ctl nibble");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule